// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of peripheral interrupt lines and a CPU core. Each line has a CPU-side pending flag, which the block sets whenever the line fires, whether or not the line is enabled. A byte-wide enable register gates the flags. Among the flagged and enabled lines, the one with the highest fixed priority is selected. After a modelled call delay the block presents the CPU with a one-cycle vector strobe, the source index and the vector address to jump to.

The block keeps a record of which priority levels are in service. A running service can be preempted only by a request of strictly higher priority. A return strobe from the CPU closes the innermost service and restores the level it interrupted, or idle if there was none.

Sources come in two kinds:
- **Level sources** re-set their flag on every cycle that their line is high.
- **Edge sources** set their flag once per rising edge.

A parameter selects which sources have their flag cleared by hardware when the vector is taken. Software clears the other flags through the register port. Priority follows the source index, with index 5 the highest.

Top module: `nested_irq_ctrl`

## Requirements
- R1: Register select 0 is the enable register. Bit 5 is the watchdog, bit 4 port 1, bit 3 serial-1 transmit, bit 2 serial-0 transmit, bit 1 port 2 and bit 0 radio. Select 1 reads the pending flags in the same bit positions. Bits 7:6 always read 0. After reset the enables, the flags and `vec_valid` are all 0.
- R2: A source event sets its pending flag whether or not the source is enabled.
- R3: A flagged source is vectored only while its enable bit is 1. A flag latched while the source was disabled is taken once the source is enabled.
- R4: While a service is running, only a request of strictly higher index starts a new vector. Requests of equal or lower index stay pending.
- R5: A pulse on `reti` ends the innermost service and restores the interrupted level, or idle if there was none. A request held back by that level is then vectored.
- R6: From idle, `vec_valid` is high for exactly one cycle. It rises 7 clock cycles after the edge that first samples the request: one cycle to detect and six for the call.
- R7: Sources in the hardware-clear set (default: bit 0 only) lose their flag when their vector is taken. Other flags stay set.
- R8: Level sources (bits 4 and 1) set their flag on every cycle the line is high. Clearing the flag while the line is still high leaves it set and causes another service.
- R9: Edge sources (bits 5, 3, 2, 0) set their flag once per rising edge. A software clear holds until a new rising edge.
- R10: `vec_addr` equals 3 + 8 × source index and `vec_src` equals the index. When several sources are eligible, the highest index is taken.
- R11: If a flag's set event and its software clear fall in the same cycle, the flag ends up set.
- R12: A write to select 1 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 6 | Peripheral request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 enables, 1 pending flags |
| reg_wdata | input | 8 | Write data (enables, or write-1-to-clear flag mask) |
| reg_rdata | output | 8 | Read data of the selected register |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | One-cycle strobe: vectored call taken |
| vec_addr | output | 16 | Vector address of the taken source |
| vec_src | output | 3 | Index of the taken source |

## Verification
The directed cases go after the following faults:
- **Equal-priority wait.** A request at the level already in service must wait. A comparison written as "greater or equal" would re-enter the running service in a loop.
- **Restore on return.** A return must restore the interrupted level rather than drop to idle. A design that cleared all nesting on return would vector a lower request too early.
- **Level sources.** A level line that is still high must survive a software clear and cause a second service.
- **Edge sources.** An edge line held high must not set its flag again after a clear.
- **Set against clear.** A set and a clear in the same cycle must leave the flag set. A design that gave the clear priority would lose that event.

The response latency is counted edge by edge, so a missing or extra pipeline stage shows as a wrong cycle count. A long run of random line activity and random clears, with every enable off, is compared each cycle against a flag model in the bench. This catches lost or spurious flag updates and any vector taken while disabled.

// File: rtl/nic_pkg.sv
package nic_pkg;

  // call sequencer states
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_CALL = 1'b1
  } seq_state_e;

  // byte stride between consecutive vector entries (shift amount)
  localparam int unsigned VEC_SHIFT = 3;

endpackage

// File: rtl/nic_flag_cell.sv
// One CPU-side pending flag with its request-edge detector.
module nic_flag_cell #(
  parameter bit IS_LEVEL = 1'b0,
  parameter bit HW_CLR   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic sw_clr,
  input  logic take,
  output logic flag
);

  logic req_q;
  logic flag_q;
  logic flag_d;
  logic set_ev;
  logic clr_ev;

  always_comb begin
    if (IS_LEVEL) begin
      set_ev = req;
    end else begin
      set_ev = req & ~req_q;
    end
    clr_ev = sw_clr | (take & HW_CLR);
    // a set in the same cycle as a clear wins
    flag_d = set_ev | (flag_q & ~clr_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/nic_pick.sv
// Selects the highest-index request that lies strictly above every
// active service level.
module nic_pick #(
  parameter int unsigned NSRC  = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NSRC-1:0]  req_vec,
  input  logic [NSRC-1:0]  active,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [NSRC-1:0] above_all;
  logic [NSRC-1:0] elig;

  for (genvar i = 0; i < NSRC; i++) begin : g_above
    assign above_all[i] = ~|active[NSRC-1:i];
  end

  assign elig = req_vec & above_all;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/nic_nest.sv
// Record of priority levels in service. Because nesting is strictly
// increasing, a bit set is equivalent to a stack: top = highest set bit.
module nic_nest #(
  parameter int unsigned NSRC  = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [NSRC-1:0]  active
);

  logic [NSRC-1:0] active_q;
  logic [NSRC-1:0] active_d;
  logic [NSRC-1:0] top_oh;
  logic [NSRC-1:0] push_oh;
  logic            upd_en;

  always_comb begin
    top_oh = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active_q[i]) begin
        top_oh    = '0;
        top_oh[i] = 1'b1;
      end
    end
    push_oh  = push ? (NSRC'(1) << push_idx) : '0;
    upd_en   = push | pop;
    active_d = (active_q & ~(pop ? top_oh : '0)) | push_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
    end
  end

  assign active = active_q;

endmodule

// File: rtl/nic_seq.sv
// Detect-then-call sequencer: captures the winner, waits CALL_LAT
// cycles, then fires the vector strobe.
module nic_seq
  import nic_pkg::*;
#(
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned CALL_LAT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  output logic             start,
  output logic             fire,
  output logic [IDX_W-1:0] take_idx,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr,
  output logic [IDX_W-1:0] vec_src
);

  localparam int unsigned CNT_W = $clog2(CALL_LAT + 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q;
  logic [VEC_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0] src_q;

  always_comb begin
    start = (st_q == SEQ_IDLE) && hit;
    fire  = (st_q == SEQ_CALL) && (cnt_q == CNT_W'(CALL_LAT - 1));
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (hit) begin
          st_d  = SEQ_CALL;
          cnt_d = '0;
          idx_d = idx;
        end
      end
      SEQ_CALL: begin
        if (fire) begin
          st_d = SEQ_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
    addr_d = VEC_W'(VEC_BASE) + (VEC_W'(idx_q) << VEC_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      src_q  <= '0;
    end else if (fire) begin
      addr_q <= addr_d;
      src_q  <= idx_q;
    end
  end

  assign take_idx  = idx_q;
  assign vec_valid = valid_q;
  assign vec_addr  = addr_q;
  assign vec_src   = src_q;

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int unsigned     NSRC         = 6,
  parameter int unsigned     REG_W        = 8,
  parameter int unsigned     VEC_W        = 16,
  parameter int unsigned     VEC_BASE     = 3,
  parameter int unsigned     CALL_LAT     = 6,
  parameter logic [NSRC-1:0] LEVEL_MASK   = 6'b010010,
  parameter logic [NSRC-1:0] AUTOCLR_MASK = 6'b000001,
  parameter int unsigned     IDX_W        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             reti,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr,
  output logic [IDX_W-1:0] vec_src
);

  logic            rst_meta;
  logic            rst_sync_n;
  logic [NSRC-1:0] en_q;
  logic            en_we;
  logic [NSRC-1:0] sw_clr;
  logic [NSRC-1:0] take_oh;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] active;
  logic            hit;
  logic [IDX_W-1:0] cand_idx;
  logic            start;
  logic            fire;
  logic [IDX_W-1:0] take_idx;
  logic            unused_wdata;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // enable register
  assign en_we = reg_we & ~reg_sel;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= reg_wdata[NSRC-1:0];
    end
  end

  assign sw_clr       = (reg_we & reg_sel) ? reg_wdata[NSRC-1:0] : '0;
  assign unused_wdata = ^reg_wdata[REG_W-1:NSRC];
  assign take_oh      = fire ? (NSRC'(1) << take_idx) : '0;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    nic_flag_cell #(
      .IS_LEVEL (LEVEL_MASK[s]),
      .HW_CLR   (AUTOCLR_MASK[s])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .req    (irq_req[s]),
      .sw_clr (sw_clr[s]),
      .take   (take_oh[s]),
      .flag   (flags[s])
    );
  end

  nic_pick #(
    .NSRC  (NSRC),
    .IDX_W (IDX_W)
  ) u_pick (
    .req_vec (flags & en_q),
    .active  (active),
    .hit     (hit),
    .idx     (cand_idx)
  );

  nic_seq #(
    .IDX_W    (IDX_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .CALL_LAT (CALL_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hit       (hit),
    .idx       (cand_idx),
    .start     (start),
    .fire      (fire),
    .take_idx  (take_idx),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .vec_src   (vec_src)
  );

  nic_nest #(
    .NSRC  (NSRC),
    .IDX_W (IDX_W)
  ) u_nest (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (fire),
    .push_idx (take_idx),
    .pop      (reti),
    .active   (active)
  );

  // read mux, upper bits zero
  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[NSRC-1:0] = flags;
    end else begin
      reg_rdata[NSRC-1:0] = en_q;
    end
  end

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int unsigned     NSRC       = 6,
  parameter int unsigned     REG_W      = 8,
  parameter int unsigned     IDX_W      = 3,
  parameter logic [NSRC-1:0] LEVEL_MASK = 6'b010010
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  irq_req,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             reti,
  input logic             vec_valid,
  input logic [IDX_W-1:0] vec_src,
  input logic [NSRC-1:0]  flags,
  input logic [NSRC-1:0]  en,
  input logic [NSRC-1:0]  active,
  input logic [NSRC-1:0]  take_oh,
  input logic             fire,
  input logic             start,
  input logic [IDX_W-1:0] cand_idx
);

  logic [NSRC-1:0] clr_all;
  assign clr_all = ((reg_we && reg_sel) ? reg_wdata[NSRC-1:0] : '0) | take_oh;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata >> NSRC) == '0); // R1

  AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (en[cand_idx] && flags[cand_idx])); // R3

  AST_STRICT_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((active >> vec_src) == NSRC'(1))); // R4

  AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !fire && (active != '0)) |=>
      (($countones(active) + 1) == $countones($past(active)))); // R5

  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R6

  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_req) & LEVEL_MASK & ~flags) == '0)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags) & ~$past(clr_all) & ~flags) == '0)); // R9

endmodule

bind nested_irq_ctrl nic_checker #(
  .NSRC       (NSRC),
  .REG_W      (REG_W),
  .IDX_W      (IDX_W),
  .LEVEL_MASK (LEVEL_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_req   (irq_req),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reti      (reti),
  .vec_valid (vec_valid),
  .vec_src   (vec_src),
  .flags     (flags),
  .en        (en_q),
  .active    (active),
  .take_oh   (take_oh),
  .fire      (fire),
  .start     (start),
  .cand_idx  (cand_idx)
);

// File: tb/nested_irq_ctrl_test.sv
`timescale 1ns/1ps
module nested_irq_ctrl_test;

  localparam int NSRC = 6;
  localparam logic [NSRC-1:0] LVL = 6'b010010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] irq_req = '0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reti = 1'b0;
  logic       vec_valid;
  logic [15:0] vec_addr;
  logic [2:0] vec_src;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nested_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reti(reti), .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_src(vec_src)
  );

  function automatic int exp_addr(input int idx);
    return 3 + 8 * idx;
  endfunction

  function automatic logic [5:0] flag_model(input logic [5:0] cur, input logic [5:0] irq,
                                            input logic [5:0] prev, input logic [5:0] clr);
    logic [5:0] set_v;
    set_v = (irq & LVL) | (irq & ~prev & ~LVL);
    return set_v | (cur & ~clr);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq_req[i] = 1'b1;
    @(negedge clk); irq_req[i] = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic wait_vec(input int max_cyc, output bit got, output int src, output int addr);
    got = 1'b0; src = -1; addr = -1;
    for (int c = 0; c < max_cyc && !got; c++) begin
      @(negedge clk);
      if (vec_valid) begin
        got = 1'b1; src = int'(vec_src); addr = int'(vec_addr);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    bit got;
    int src, addr, n;
    logic [5:0] model, prev, irq_n, clr_n;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(1'b0, rd); check("R1 enable reset", rd, 8'h00);
    reg_read(1'b1, rd); check("R1 flags reset", rd, 8'h00);
    check("R1 vec_valid reset", vec_valid, 0);

    // R1 unused bits read zero
    reg_write(1'b0, 8'hFF);
    @(negedge clk); reg_read(1'b0, rd); check("R1 upper bits zero", rd, 8'h3F);
    reg_write(1'b0, 8'h00);

    // R2 / R3 latch while disabled, taken once enabled
    pulse(3);
    wait_vec(20, got, src, addr); check("R3 disabled not vectored", got, 0);
    reg_read(1'b1, rd); check("R2 flag latched while disabled", rd, 8'h08);
    reg_write(1'b0, 8'h08);
    wait_vec(12, got, src, addr);
    check("R3 vectored after enable", got, 1);
    check("R10 src3 index", src, 3);
    check("R10 src3 address", addr, exp_addr(3));
    reg_write(1'b1, 8'h00);
    @(negedge clk); reg_read(1'b1, rd); check("R12 zero write keeps flag", rd, 8'h08);
    reg_write(1'b1, 8'h08);
    @(negedge clk); reg_read(1'b1, rd); check("R12 write-1 clears", rd, 8'h00);
    do_reti();

    // R6 latency and R7 hardware clear on source 0
    reg_write(1'b0, 8'h01);
    @(negedge clk); irq_req[0] = 1'b1;
    n = 0; got = 0;
    while (!got && n < 30) begin
      @(negedge clk);
      if (n == 0) irq_req[0] = 1'b0;
      n++;
      if (vec_valid) begin got = 1; src = int'(vec_src); addr = int'(vec_addr); end
    end
    // capture edge + 7 cycles -> strobe seen at the 8th falling edge
    check("R6 response latency", n, 8);
    check("R10 src0 address", addr, exp_addr(0));
    @(negedge clk); check("R6 strobe one cycle", vec_valid, 0);
    reg_read(1'b1, rd); check("R7 autoclear flag0", rd, 8'h00);
    do_reti();

    // R4 / R5 nesting
    reg_write(1'b0, 8'h3F);
    pulse(2);
    wait_vec(12, got, src, addr); check("R4 first service src2", src, 2);
    check("R10 src2 address", addr, exp_addr(2));
    reg_read(1'b1, rd); check("R7 flag2 stays set", rd, 8'h04);
    reg_write(1'b1, 8'h04);
    pulse(2);
    pulse(1);
    wait_vec(30, got, src, addr); check("R4 equal and lower wait", got, 0);
    pulse(5);
    wait_vec(12, got, src, addr); check("R4 higher preempts", src, 5);
    check("R10 src5 address", addr, exp_addr(5));
    reg_write(1'b1, 8'h20);
    do_reti();
    wait_vec(20, got, src, addr); check("R5 restores level 2", got, 0);
    do_reti();
    wait_vec(12, got, src, addr); check("R5 R10 highest pending src2", src, 2);
    reg_write(1'b1, 8'h04);
    do_reti();
    wait_vec(12, got, src, addr); check("R5 lower runs after return", src, 1);
    check("R10 src1 address", addr, exp_addr(1));
    reg_write(1'b1, 8'h02);
    do_reti();

    // R8 level source re-service
    reg_write(1'b0, 8'h10);
    @(negedge clk); irq_req[4] = 1'b1;
    wait_vec(12, got, src, addr); check("R8 level service", src, 4);
    reg_write(1'b1, 8'h10);
    do_reti();
    wait_vec(12, got, src, addr); check("R8 re-service while high", src, 4);
    @(negedge clk); irq_req[4] = 1'b0;
    reg_write(1'b1, 8'h10);
    do_reti();
    wait_vec(20, got, src, addr); check("R8 no service after drop", got, 0);

    // R8 / R9 / R11 flag behaviour with everything disabled
    reg_write(1'b0, 8'h00);
    @(negedge clk); irq_req[4] = 1'b1;
    repeat (2) @(negedge clk);
    reg_write(1'b1, 8'h10);
    @(negedge clk); reg_read(1'b1, rd); check("R8 clear while high", rd, 8'h10);
    irq_req[4] = 1'b0;
    reg_write(1'b1, 8'h10);
    @(negedge clk); reg_read(1'b1, rd); check("R8 clear after drop", rd, 8'h00);

    @(negedge clk); irq_req[3] = 1'b1;
    repeat (2) @(negedge clk);
    reg_write(1'b1, 8'h08);
    @(negedge clk); reg_read(1'b1, rd); check("R9 edge clear sticks", rd, 8'h00);
    repeat (4) @(negedge clk);
    reg_read(1'b1, rd); check("R9 no reset while held", rd, 8'h00);
    irq_req[3] = 1'b0;
    @(negedge clk); irq_req[3] = 1'b1;
    @(negedge clk); reg_read(1'b1, rd); check("R9 new edge sets", rd, 8'h08);
    irq_req[3] = 1'b0;
    reg_write(1'b1, 8'h08);

    @(negedge clk);
    irq_req[3] = 1'b1; reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h08;
    @(negedge clk);
    reg_we = 1'b0; irq_req[3] = 1'b0;
    reg_read(1'b1, rd); check("R11 set beats clear", rd, 8'h08);
    reg_write(1'b1, 8'h3F);

    // random flag activity against the model, all enables off (R2 R8 R9 R11 R12)
    @(negedge clk);
    reg_sel = 1'b1;
    prev = irq_req;
    model = 6'h00;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      #1;
      check("R2 R9 random flag state", reg_rdata, {2'b00, model});
      check("R3 random no vector", vec_valid, 0);
      irq_n = 6'($urandom);
      reg_we = (($urandom % 4) == 0);
      reg_wdata = 8'($urandom);
      clr_n = reg_we ? reg_wdata[5:0] : 6'h00;
      irq_req = irq_n;
      model = flag_model(model, irq_n, prev, clr_n);
      prev = irq_n;
    end
    @(negedge clk);
    #1;
    check("R11 random final flags", reg_rdata, {2'b00, model});
    reg_we = 1'b0;
    irq_req = '0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule